// File: doc/BRIEF.md
# Dual Timer/Counter with Selectable Operating Modes

This block holds two independent timer/counters. Each one is a pair of count bytes, a high byte and a low byte. An 8-bit configuration word gives each timer its own nibble. The nibble chooses the count source, which is either a machine-cycle tick or falling edges on an external pin. It also enables or disables hardware gating and selects one of four counting structures. These are a 13-bit prescaled counter, a full 16-bit counter, an 8-bit counter with automatic reload, and a split arrangement. In the split arrangement timer 0 becomes two separate 8-bit counters.

A control word carries a run bit and an overflow flag for each timer. A flag is set when its counter wraps from all ones. It is cleared either by a per-timer acknowledge strobe from the interrupt logic or by a software write to the control word. Timer 1 also drives a single-cycle overflow strobe, which a serial baud generator can use. All four count bytes can be loaded and read through a byte-select port.

Top module: `dual_tmr_top`

## Requirements
- R1: After reset, all four count bytes, the configuration word, the control word, both overflow flags and the timer 1 strobe are zero.
- R2: In the configuration word, bits 7:4 configure timer 1 and bits 3:0 configure timer 0. Within each nibble, bit 3 enables gating, bit 2 selects the external pin (1) or the tick (0), and bits 1:0 select the mode. The control word reads back as bit 7 = timer 1 flag, bit 6 = timer 1 run, bit 5 = timer 0 flag, bit 4 = timer 0 run, and bits 3:0 read 0. A control write supplies bits 7:4 in that order.
- R3: Mode 1 (bits 1:0 = 01) counts {high, low} as 16 bits. Wrapping from FFFF to 0000 sets the flag.
- R4: Mode 0 (00) treats the low 5 bits of the low byte as a prescaler below the high byte, which forms a 13-bit counter. The upper 3 bits of the low byte are unchanged, and a wrap from 1FFF sets the flag.
- R5: Mode 2 (10) counts the low byte only. When the low byte wraps, it is loaded from the high byte, the high byte is unchanged, and the flag is set.
- R6: Mode 3 (11) on timer 0 makes its low byte an 8-bit counter under timer 0's own controls, and its overflow sets the timer 0 flag. The high byte counts ticks while the timer 1 run bit is set, and its wrap sets the timer 1 flag. Timer 1 placed in mode 3 holds its count.
- R7: With gating enabled, a timer counts only while its gate pin is high, as seen after synchronisation. With gating disabled, the gate pin has no effect.
- R8: With the external source selected, a timer counts each synchronised 1-to-0 transition of its count pin. Rising edges and the tick are ignored.
- R9: An acknowledge strobe clears the flag. A control write loads the flag value. When a hardware set and an acknowledge arrive in the same cycle, the set wins.
- R10: The timer 1 strobe is high for one clock each time timer 1 wraps in modes 0 to 2. While timer 0 is split, timer 1 counts without needing its run bit, still produces the strobe, and does not set the timer 1 flag.
- R11: The byte select addresses 0 = timer 0 low, 1 = timer 0 high, 2 = timer 1 low, 3 = timer 1 high. When a byte write and an increment of the same timer fall in the same cycle, the written value wins.
- R12: A timer whose run bit is clear holds its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Machine-cycle count enable |
| cnt_pin_i | input | 2 | External count pins, index = timer |
| gate_pin_i | input | 2 | Gate pins, index = timer |
| cfg_wr_i | input | 1 | Configuration word write strobe |
| cfg_wdata_i | input | 8 | Configuration word write value |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_wdata_i | input | 4 | Control bits {flag1, run1, flag0, run0} |
| ack_i | input | 2 | Flag acknowledge strobes, index = timer |
| byte_sel_i | input | 2 | Count byte select |
| byte_wr_i | input | 1 | Count byte write strobe |
| byte_wdata_i | input | BYTE_W | Count byte write value |
| byte_rdata_o | output | BYTE_W | Selected count byte |
| cfg_o | output | 8 | Configuration word |
| ctl_o | output | 8 | Control word |
| ovf_flag_o | output | 2 | Overflow flags, index = timer |
| t1_strobe_o | output | 1 | Timer 1 wrap strobe |

## Verification
The bench uses the default parameters: 8-bit count bytes, a 5-bit prescaler in the 13-bit mode, and two synchroniser stages. Because any count byte can be preloaded, every wrap in every mode is a few ticks away. The prescaler carry at 1F, the reload, and the split-mode flag routing can therefore each be reached with short tick bursts and checked to the exact cycle. With two synchroniser stages the pin latency is small, so the gating and edge-count cases settle within a handful of cycles before each counted tick.

// File: rtl/dual_tmr_pkg.sv
package dual_tmr_pkg;

   localparam int CFG_W = 4;
   localparam int N_TMR = 2;

   typedef enum logic [1:0] {
      MD_PRE13 = 2'b00,
      MD_FULL  = 2'b01,
      MD_RLD8  = 2'b10,
      MD_SPLIT = 2'b11
   } tmr_mode_e;

   typedef struct packed {
      logic      gate_en;
      logic      ext_src;
      tmr_mode_e mode;
   } tmr_cfg_t;

endpackage

// File: rtl/dual_tmr_sync.sv
module dual_tmr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic lvl_o,
   output logic fall_o
);

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("dual_tmr_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign lvl_o  = chain_q[STAGES-1];
   assign fall_o = prev_q & ~chain_q[STAGES-1];

   // R8: a detected falling edge lasts one cycle
   a_r8_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o);

endmodule

// File: rtl/dual_tmr_core.sv
module dual_tmr_core
   import dual_tmr_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int PRE_W     = 5,
   parameter bit HAS_SPLIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  tmr_mode_e         mode_i,
   input  logic              inc_i,
   input  logic              inc_hi_i,
   input  logic              wr_lo_i,
   input  logic              wr_hi_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic [BYTE_W-1:0] lo_o,
   output logic [BYTE_W-1:0] hi_o,
   output logic              ovf_o,
   output logic              ovf_hi_o
);

   localparam int                WIDE_W = 2 * BYTE_W;
   localparam logic [BYTE_W-1:0] ONE_B  = BYTE_W'(1);
   localparam logic [WIDE_W-1:0] ONE_W  = WIDE_W'(1);
   localparam logic [PRE_W-1:0]  ONE_P  = PRE_W'(1);

   logic [BYTE_W-1:0] lo_q, hi_q, lo_n, hi_n;
   logic [WIDE_W-1:0] wide_sum;
   logic              ovf_raw, ovf_hi_raw, any_wr;

   generate
      if (PRE_W < 1 || PRE_W >= BYTE_W) begin : g_bad_pre
         $error("dual_tmr_core: PRE_W must lie in 1..BYTE_W-1");
      end
   endgenerate

   assign wide_sum = {hi_q, lo_q} + ONE_W;
   assign any_wr   = wr_lo_i | wr_hi_i;

   always_comb begin
      lo_n       = lo_q;
      hi_n       = hi_q;
      ovf_raw    = 1'b0;
      ovf_hi_raw = 1'b0;
      unique case (mode_i)
         MD_PRE13: if (inc_i) begin
            if (&lo_q[PRE_W-1:0]) begin
               lo_n[PRE_W-1:0] = '0;
               hi_n            = hi_q + ONE_B;
               ovf_raw         = &hi_q;
            end else begin
               lo_n[PRE_W-1:0] = lo_q[PRE_W-1:0] + ONE_P;
            end
         end
         MD_FULL: if (inc_i) begin
            {hi_n, lo_n} = wide_sum;
            ovf_raw      = &{hi_q, lo_q};
         end
         MD_RLD8: if (inc_i) begin
            if (&lo_q) begin
               lo_n    = hi_q;
               ovf_raw = 1'b1;
            end else begin
               lo_n = lo_q + ONE_B;
            end
         end
         MD_SPLIT: if (HAS_SPLIT) begin
            if (inc_i) begin
               lo_n    = lo_q + ONE_B;
               ovf_raw = &lo_q;
            end
            if (inc_hi_i) begin
               hi_n       = hi_q + ONE_B;
               ovf_hi_raw = &hi_q;
            end
         end
         default: ;
      endcase
      if (wr_lo_i) lo_n = wdata_i;
      if (wr_hi_i) hi_n = wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         lo_q <= lo_n;
         hi_q <= hi_n;
      end
   end

   assign lo_o     = lo_q;
   assign hi_o     = hi_q;
   assign ovf_o    = ovf_raw & ~any_wr;
   assign ovf_hi_o = ovf_hi_raw & ~any_wr;

   // R12: no increment and no write leaves the count alone
   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !inc_hi_i && !any_wr) |=> ($stable(lo_q) && $stable(hi_q)));

   // R5: a low-byte wrap in reload mode takes the high byte
   a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MD_RLD8 && inc_i && (&lo_q) && !any_wr)
      |=> (lo_q == $past(hi_q) && $stable(hi_q)));

   // R11: a byte write wins over a same-cycle increment
   a_r11_wr_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo_i |=> lo_q == $past(wdata_i));

   generate
      if (!HAS_SPLIT) begin : g_stop
         // R6: the timer without a split holds in mode 3
         a_r6_stop: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_i == MD_SPLIT && !any_wr) |=> ($stable(lo_q) && $stable(hi_q)));
      end
   endgenerate

endmodule

// File: rtl/dual_tmr_top.sv
module dual_tmr_top
   import dual_tmr_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int PRE_W       = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [1:0]        cnt_pin_i,
   input  logic [1:0]        gate_pin_i,
   input  logic              cfg_wr_i,
   input  logic [7:0]        cfg_wdata_i,
   input  logic              ctl_wr_i,
   input  logic [3:0]        ctl_wdata_i,
   input  logic [1:0]        ack_i,
   input  logic [1:0]        byte_sel_i,
   input  logic              byte_wr_i,
   input  logic [BYTE_W-1:0] byte_wdata_i,
   output logic [BYTE_W-1:0] byte_rdata_o,
   output logic [7:0]        cfg_o,
   output logic [7:0]        ctl_o,
   output logic [1:0]        ovf_flag_o,
   output logic              t1_strobe_o
);

   localparam int CFG_TOTAL = N_TMR * CFG_W;

   logic [CFG_TOTAL-1:0] cfg_q;
   tmr_cfg_t             cfg0, cfg1;
   logic                 run0_q, run1_q, flag0_q, flag1_q, strobe_q;
   logic [N_TMR-1:0]     pin_fall, gate_lvl;
   logic                 src0, src1, inc0, inc1, inc_hi0, split;
   logic                 ovf0, ovf1, ovf_hi0, ovf_hi1, set1;
   logic [BYTE_W-1:0]    lo0, hi0, lo1, hi1;
   logic [3:0]           byte_we;

   generate
      if (CFG_TOTAL != 8) begin : g_bad_cfg
         $error("dual_tmr_top: configuration word must be 8 bits");
      end
      for (genvar t = 0; t < N_TMR; t++) begin : g_pins
         logic cnt_lvl_unused;
         logic gate_fall_unused;
         dual_tmr_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
            .clk(clk), .rst_n(rst_n), .pin_i(cnt_pin_i[t]),
            .lvl_o(cnt_lvl_unused), .fall_o(pin_fall[t]));
         dual_tmr_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
            .clk(clk), .rst_n(rst_n), .pin_i(gate_pin_i[t]),
            .lvl_o(gate_lvl[t]), .fall_o(gate_fall_unused));
      end
      for (genvar b = 0; b < 4; b++) begin : g_we
         assign byte_we[b] = byte_wr_i && (byte_sel_i == 2'(b));
      end
   endgenerate

   assign cfg0  = tmr_cfg_t'(cfg_q[CFG_W-1:0]);
   assign cfg1  = tmr_cfg_t'(cfg_q[CFG_TOTAL-1:CFG_W]);
   assign split = (cfg0.mode == MD_SPLIT);

   assign src0    = (cfg0.ext_src ? pin_fall[0] : tick_i) & (~cfg0.gate_en | gate_lvl[0]);
   assign src1    = (cfg1.ext_src ? pin_fall[1] : tick_i) & (~cfg1.gate_en | gate_lvl[1]);
   assign inc0    = run0_q & src0;
   assign inc1    = split ? src1 : (run1_q & src1);
   assign inc_hi0 = split & run1_q & tick_i;

   dual_tmr_core #(.BYTE_W(BYTE_W), .PRE_W(PRE_W), .HAS_SPLIT(1'b1)) u_core0 (
      .clk(clk), .rst_n(rst_n), .mode_i(cfg0.mode), .inc_i(inc0),
      .inc_hi_i(inc_hi0), .wr_lo_i(byte_we[0]), .wr_hi_i(byte_we[1]),
      .wdata_i(byte_wdata_i), .lo_o(lo0), .hi_o(hi0),
      .ovf_o(ovf0), .ovf_hi_o(ovf_hi0));

   dual_tmr_core #(.BYTE_W(BYTE_W), .PRE_W(PRE_W), .HAS_SPLIT(1'b0)) u_core1 (
      .clk(clk), .rst_n(rst_n), .mode_i(cfg1.mode), .inc_i(inc1),
      .inc_hi_i(1'b0), .wr_lo_i(byte_we[2]), .wr_hi_i(byte_we[3]),
      .wdata_i(byte_wdata_i), .lo_o(lo1), .hi_o(hi1),
      .ovf_o(ovf1), .ovf_hi_o(ovf_hi1));

   assign set1 = split ? ovf_hi0 : ovf1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q    <= '0;
         run0_q   <= 1'b0;
         run1_q   <= 1'b0;
         flag0_q  <= 1'b0;
         flag1_q  <= 1'b0;
         strobe_q <= 1'b0;
      end else begin
         strobe_q <= ovf1;
         if (cfg_wr_i) cfg_q <= cfg_wdata_i;
         if (ctl_wr_i) begin
            {flag1_q, run1_q, flag0_q, run0_q} <= ctl_wdata_i;
         end else begin
            flag0_q <= ovf0 | (flag0_q & ~ack_i[0]);
            flag1_q <= set1 | (flag1_q & ~ack_i[1]);
         end
      end
   end

   always_comb begin
      unique case (byte_sel_i)
         2'd0:    byte_rdata_o = lo0;
         2'd1:    byte_rdata_o = hi0;
         2'd2:    byte_rdata_o = lo1;
         default: byte_rdata_o = hi1;
      endcase
   end

   assign cfg_o       = cfg_q;
   assign ctl_o       = {flag1_q, run1_q, flag0_q, run0_q, 4'b0000};
   assign ovf_flag_o  = {flag1_q, flag0_q};
   assign t1_strobe_o = strobe_q;

   // R9: a counter wrap raises its flag unless software writes the control word
   a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf0 && !ctl_wr_i) |=> ovf_flag_o[0]);

   // R9: an acknowledge without a same-cycle wrap clears the flag
   a_r9_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i[0] && !ovf0 && !ctl_wr_i) |=> !ovf_flag_o[0]);

   // R10: the strobe only follows timer 1 outside mode 3
   a_r10_strobe_mode: assert property (@(posedge clk) disable iff (!rst_n)
      t1_strobe_o |-> $past(cfg1.mode != MD_SPLIT));

   // R10: in split mode only the timer 0 high byte may raise the timer 1 flag
   a_r10_split_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (split && !ovf_hi0 && !flag1_q && !ctl_wr_i && !cfg_wr_i) |=> !ovf_flag_o[1]);

   // R6: timer 1 has no split half
   a_r6_no_t1_hi: assert property (@(posedge clk) disable iff (!rst_n)
      !ovf_hi1);

endmodule

// File: tb/dual_tmr_top_tb_top.sv
`timescale 1ns/1ps
module dual_tmr_top_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic [1:0] cnt_pin = 2'b11;
   logic [1:0] gate_pin = 2'b00;
   logic       cfg_wr = 1'b0;
   logic [7:0] cfg_wd = '0;
   logic       ctl_wr = 1'b0;
   logic [3:0] ctl_wd = '0;
   logic [1:0] ack = '0;
   logic [1:0] sel = '0;
   logic       bwr = 1'b0;
   logic [7:0] bwd = '0;
   logic [7:0] rdata, cfg_o, ctl_o;
   logic [1:0] flags;
   logic       strobe;

   int   n_chk = 0;
   int   n_bad = 0;
   logic rd_req = 1'b0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #2.5 clk = ~clk;

   dual_tmr_top dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cnt_pin_i(cnt_pin),
      .gate_pin_i(gate_pin), .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wd),
      .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wd), .ack_i(ack),
      .byte_sel_i(sel), .byte_wr_i(bwr), .byte_wdata_i(bwd),
      .byte_rdata_o(rdata), .cfg_o(cfg_o), .ctl_o(ctl_o),
      .ovf_flag_o(flags), .t1_strobe_o(strobe));

   // monitor: pops expected bytes and compares with the read port
   always @(posedge clk) begin
      logic [7:0] e;
      string      t;
      #1;
      if (rd_req && exp_q.size() > 0) begin
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_chk++;
         if (rdata !== e) begin
            n_bad++;
            $display("FAIL %s: byte sel=%0d got %h exp %h", t, sel, rdata, e);
         end
      end
   end

   task automatic expect_rd(input logic [1:0] s, input logic [7:0] v, input string t);
      sel = s;
      exp_q.push_back(v);
      tag_q.push_back(t);
      rd_req = 1'b1;
      @(posedge clk); @(negedge clk);
      rd_req = 1'b0;
   endtask

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string t);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h exp %h", t, act, exp);
      end
   endtask

   task automatic wr_cfg(input logic [7:0] v);
      cfg_wd = v; cfg_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic wr_ctl(input logic [3:0] v);
      ctl_wd = v; ctl_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic wr_byte(input logic [1:0] s, input logic [7:0] v);
      sel = s; bwd = v; bwr = 1'b1;
      @(posedge clk); @(negedge clk);
      bwr = 1'b0;
   endtask

   task automatic ticks(input int n);
      tick_i = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk);
      tick_i = 1'b0;
   endtask

   task automatic summary;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      expect_rd(2'd0, 8'h00, "R1 lo0");
      expect_rd(2'd1, 8'h00, "R1 hi0");
      expect_rd(2'd2, 8'h00, "R1 lo1");
      expect_rd(2'd3, 8'h00, "R1 hi1");
      chk(cfg_o, 8'h00, "R1 cfg");
      chk(ctl_o, 8'h00, "R1 ctl");
      chk({6'b0, flags}, 8'h00, "R1 flags");
      chk({7'b0, strobe}, 8'h00, "R1 strobe");

      // R2 layout, R3 16-bit mode on timer 0
      wr_cfg(8'h21);
      chk(cfg_o, 8'h21, "R2 cfg readback");
      wr_byte(2'd0, 8'hFD);
      wr_byte(2'd1, 8'hFF);
      wr_ctl(4'h1);
      chk(ctl_o, 8'h10, "R2 ctl run0 at bit4");
      ticks(2);
      expect_rd(2'd0, 8'hFF, "R3 lo before wrap");
      chk({7'b0, flags[0]}, 8'h00, "R3 no flag yet");
      ticks(1);
      expect_rd(2'd0, 8'h00, "R3 lo wrap");
      expect_rd(2'd1, 8'h00, "R3 hi wrap");
      chk({7'b0, flags[0]}, 8'h01, "R3 flag set");
      chk(ctl_o, 8'h30, "R2 ctl flag0 at bit5");

      // R9 acknowledge clears, R12 stopped timer holds
      ack = 2'b01; @(posedge clk); @(negedge clk); ack = 2'b00;
      chk({7'b0, flags[0]}, 8'h00, "R9 ack clears");
      wr_ctl(4'h0);
      ticks(5);
      expect_rd(2'd0, 8'h00, "R12 hold lo");
      wr_ctl(4'h2);
      chk({7'b0, flags[0]}, 8'h01, "R9 ctl write sets");
      wr_ctl(4'h0);
      chk({7'b0, flags[0]}, 8'h00, "R9 ctl write clears");

      // R4 13-bit mode
      wr_cfg(8'h00);
      wr_byte(2'd0, 8'hFE);
      wr_byte(2'd1, 8'hFF);
      wr_ctl(4'h1);
      ticks(1);
      expect_rd(2'd0, 8'hFF, "R4 prescaler at 1F");
      ticks(1);
      expect_rd(2'd0, 8'hE0, "R4 upper bits kept");
      expect_rd(2'd1, 8'h00, "R4 hi wrap");
      chk({7'b0, flags[0]}, 8'h01, "R4 flag");
      wr_ctl(4'h1);
      ticks(33);
      expect_rd(2'd0, 8'hE1, "R4 prescale lo");
      expect_rd(2'd1, 8'h01, "R4 carry into hi");

      // R5 reload mode
      wr_ctl(4'h0);
      wr_cfg(8'h02);
      wr_byte(2'd1, 8'h80);
      wr_byte(2'd0, 8'hFE);
      wr_ctl(4'h1);
      ticks(2);
      expect_rd(2'd0, 8'h80, "R5 reload");
      expect_rd(2'd1, 8'h80, "R5 hi kept");
      chk({7'b0, flags[0]}, 8'h01, "R5 flag");
      ticks(1);
      expect_rd(2'd0, 8'h81, "R5 after reload");

      // R11 write beats increment; byte mapping
      sel = 2'd0; bwd = 8'h55; bwr = 1'b1; tick_i = 1'b1;
      @(posedge clk); @(negedge clk);
      bwr = 1'b0; tick_i = 1'b0;
      expect_rd(2'd0, 8'h55, "R11 write wins");
      wr_byte(2'd2, 8'h11);
      wr_byte(2'd3, 8'h22);
      expect_rd(2'd1, 8'h80, "R11 sel1");
      expect_rd(2'd2, 8'h11, "R11 sel2");
      expect_rd(2'd3, 8'h22, "R11 sel3");

      // R7 gating
      wr_ctl(4'h0);
      wr_cfg(8'h09);
      wr_byte(2'd0, 8'h00);
      wr_byte(2'd1, 8'h00);
      wr_ctl(4'h1);
      ticks(3);
      expect_rd(2'd0, 8'h00, "R7 gate low blocks");
      gate_pin[0] = 1'b1;
      repeat (4) @(negedge clk);
      ticks(3);
      expect_rd(2'd0, 8'h03, "R7 gate high counts");
      wr_cfg(8'h01);
      gate_pin[0] = 1'b0;
      repeat (4) @(negedge clk);
      ticks(2);
      expect_rd(2'd0, 8'h05, "R7 gate ignored when off");

      // R8 external pin falling edges
      wr_cfg(8'h05);
      ticks(4);
      expect_rd(2'd0, 8'h05, "R8 tick ignored");
      for (int k = 0; k < 3; k++) begin
         cnt_pin[0] = 1'b0;
         repeat (5) @(negedge clk);
         cnt_pin[0] = 1'b1;
         repeat (5) @(negedge clk);
      end
      expect_rd(2'd0, 8'h08, "R8 three falls");

      // R6 split mode
      wr_ctl(4'h0);
      wr_cfg(8'h33);
      wr_byte(2'd0, 8'hFE);
      wr_byte(2'd1, 8'hFE);
      wr_byte(2'd2, 8'h40);
      wr_byte(2'd3, 8'h40);
      wr_ctl(4'h1);
      ticks(2);
      expect_rd(2'd0, 8'h00, "R6 low half wraps");
      expect_rd(2'd1, 8'hFE, "R6 high half needs run1");
      chk({6'b0, flags}, 8'h01, "R6 low half sets flag0");
      wr_ctl(4'h5);
      ticks(2);
      expect_rd(2'd1, 8'h00, "R6 high half wraps");
      expect_rd(2'd0, 8'h02, "R6 low half continues");
      chk({6'b0, flags}, 8'h02, "R6 high half sets flag1");
      expect_rd(2'd2, 8'h40, "R6 timer1 stopped lo");
      expect_rd(2'd3, 8'h40, "R6 timer1 stopped hi");
      chk({7'b0, strobe}, 8'h00, "R10 no strobe in mode 3");

      // R10 strobe in reload mode
      wr_ctl(4'h0);
      wr_cfg(8'h20);
      wr_byte(2'd2, 8'hFE);
      wr_byte(2'd3, 8'hF0);
      wr_ctl(4'h4);
      ticks(1);
      chk({7'b0, strobe}, 8'h00, "R10 strobe idle");
      tick_i = 1'b1; @(posedge clk); @(negedge clk); tick_i = 1'b0;
      chk({7'b0, strobe}, 8'h01, "R10 strobe high");
      chk({7'b0, flags[1]}, 8'h01, "R10 flag1 set");
      @(posedge clk); @(negedge clk);
      chk({7'b0, strobe}, 8'h00, "R10 strobe one cycle");
      expect_rd(2'd2, 8'hF0, "R10 reload lo1");

      // R10 timer 1 while timer 0 is split
      wr_ctl(4'h0);
      wr_cfg(8'h23);
      wr_byte(2'd2, 8'hFF);
      tick_i = 1'b1; @(posedge clk); @(negedge clk); tick_i = 1'b0;
      chk({7'b0, strobe}, 8'h01, "R10 strobe during split");
      chk({7'b0, flags[1]}, 8'h00, "R10 no flag1 during split");
      expect_rd(2'd2, 8'hF0, "R10 runs without run1");

      // R9 set wins over acknowledge
      wr_ctl(4'h0);
      wr_cfg(8'h01);
      wr_byte(2'd0, 8'hFF);
      wr_byte(2'd1, 8'hFF);
      wr_ctl(4'h1);
      tick_i = 1'b1; ack = 2'b01;
      @(posedge clk); @(negedge clk);
      tick_i = 1'b0; ack = 2'b00;
      chk({7'b0, flags[0]}, 8'h01, "R9 set beats ack");

      repeat (2) @(negedge clk);
      summary();
      $finish;
   end

endmodule